// File: doc/BRIEF.md
# Tolerant Mask-Match Segment Finder

This block looks at the hit pattern of one chamber layer, cell by cell, and reports which track-segment positions it supports. Every wire of a cell carries two hit flags: an early-drift flag ("prompt") and a late-drift flag ("delayed"). A shared table of masks lists the flags that a valid segment must show. A mask fires when the number of required flags that are missing is no larger than a limit from 0 to 3. Each firing mask lights the output pixel it is assigned to.

Four neighbouring cells are handled in parallel, and they all use the same table. The table is loaded through a write port. A new event can be accepted on every clock, which covers an event period of 132 ns with room to spare. The result appears a fixed number of clocks later, together with a valid flag. Two build variants exist. The inner-layer variant has 12 position pixels per cell. The outer-layer variant has 18 pixels per cell: 6 positions times 3 slope classes.

Top module: `seg_mask_finder`

## Requirements
- R1: While reset is high, and after it, out_valid is 0 and every pixel is 0. Reset also disables every table entry by setting its pixel code to all ones, so no pixel lights until entries are loaded.
- R2: When cfg_we is 1 on a clock edge, table entry cfg_addr takes pattern cfg_pat and pixel code cfg_code. Events presented on later clocks use the new entry.
- R3: Pattern bit 2w is the prompt flag of wire w and bit 2w+1 is its delayed flag. A cell's input uses the same layout, and cell c occupies in_hits[24c+23:24c]. The miss count of a mask is the number of bits set in the pattern but clear in the input. Input bits that the pattern does not set never add to the count.
- R4: A mask matches a cell when its miss count is at most miss_lim, which ranges from 0 to 3.
- R5: In the inner variant (OUTER=0), a matching mask with code k below 12 lights out_pix[12c+k]. Codes of 12 or more light nothing.
- R6: In the outer variant (OUTER=1), code k = 6*slope + position, where slope 0 is low momentum positive, 1 is low momentum negative and 2 is high momentum. A match lights out_pix[18c+k]. Codes of 18 or more light nothing.
- R7: Each pixel is the OR of all matching masks that carry its code, so several pixels can light in one cell for one event.
- R8: The cells are evaluated independently against the same table, so cells with identical inputs produce identical pixel groups.
- R9: out_valid rises two clocks after in_valid is sampled high, and out_pix then holds the result for that event. While out_valid is 0, out_pix is 0.
- R10: Events on consecutive clocks each produce their own result, in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An event is present on in_hits |
| in_hits | input | NCELL*2*NWIRE | Prompt/delayed flags for each cell |
| miss_lim | input | 2 | Allowed missing required flags, 0 to 3 |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | log2(NMASK) | Table entry to write |
| cfg_pat | input | 2*NWIRE | Required-flag pattern |
| cfg_code | input | 5 | Pixel code of the entry |
| out_valid | output | 1 | Result valid |
| out_pix | output | NCELL*NPIX | Lit pixels, one group per cell |

## Verification
The hardest case to reach is the exact edge of the tolerance: an input that lacks exactly miss_lim required flags must match, and one that lacks one more must not. Random hits almost never land on that edge. The stimulus therefore starts from a loaded mask pattern, clears a chosen number of its required bits, and sweeps that number against every limit. Extra hits are added on top, and table entries that share a code are also exercised, so the tolerance edge is tested together with the OR of several masks.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    SLOPE_LOW_POS = 2'd0,
    SLOPE_LOW_NEG = 2'd1,
    SLOPE_HIGH    = 2'd2
  } slope_e;

  // Pixel code for the outer variant: slope-major, position-minor.
  function automatic logic [4:0] outer_code(input slope_e s, input logic [2:0] pos);
    return 5'(int'(s) * 6 + int'(pos));
  endfunction
endpackage

// File: rtl/sf_mask_table.sv
module sf_mask_table #(
  parameter int NMASK = 16,
  parameter int PATW  = 24,
  parameter int CODEW = 5,
  parameter int ADDRW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDRW-1:0]       waddr,
  input  logic [PATW-1:0]        wpat,
  input  logic [CODEW-1:0]       wcode,
  output logic [NMASK*PATW-1:0]  pat_all,
  output logic [NMASK*CODEW-1:0] code_all
);
  logic [PATW-1:0]  pat_q  [NMASK];
  logic [CODEW-1:0] code_q [NMASK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NMASK; i++) begin
        pat_q[i]  <= '0;
        code_q[i] <= '1;
      end
    end else if (we && (int'(waddr) < NMASK)) begin
      pat_q[waddr]  <= wpat;
      code_q[waddr] <= wcode;
    end
  end

  for (genvar g = 0; g < NMASK; g++) begin : g_flat
    assign pat_all[g*PATW +: PATW]    = pat_q[g];
    assign code_all[g*CODEW +: CODEW] = code_q[g];
  end
endmodule

// File: rtl/sf_cell_match.sv
module sf_cell_match #(
  parameter int NMASK = 16,
  parameter int PATW  = 24,
  parameter int LIMW  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [PATW-1:0]       hits,
  input  logic [LIMW-1:0]       lim,
  input  logic [NMASK*PATW-1:0] pat_all,
  output logic [NMASK-1:0]      match_q
);
  localparam int CNTW = $clog2(PATW + 1);

  logic [NMASK-1:0] match_c;

  for (genvar m = 0; m < NMASK; m++) begin : g_mask
    logic [PATW-1:0] absent;
    logic [CNTW-1:0] cnt;
    assign absent = pat_all[m*PATW +: PATW] & ~hits;
    always_comb begin
      cnt = '0;
      for (int b = 0; b < PATW; b++) cnt = cnt + CNTW'(absent[b]);
    end
    assign match_c[m] = (cnt <= CNTW'(lim));
  end

  always_ff @(posedge clk) begin
    if (rst)           match_q <= '0;
    else if (in_valid) match_q <= match_c;
    else               match_q <= '0;
  end
endmodule

// File: rtl/sf_pixel_or.sv
module sf_pixel_or #(
  parameter int NMASK = 16,
  parameter int CODEW = 5,
  parameter int NPIX  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid,
  input  logic [NMASK-1:0]       match,
  input  logic [NMASK*CODEW-1:0] codes,
  output logic [NPIX-1:0]        pix_q
);
  logic [NPIX-1:0] pix_c;

  always_comb begin
    pix_c = '0;
    for (int p = 0; p < NPIX; p++)
      for (int m = 0; m < NMASK; m++)
        if (match[m] && (int'(codes[m*CODEW +: CODEW]) == p)) pix_c[p] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !valid) pix_q <= '0;
    else               pix_q <= pix_c;
  end
endmodule

// File: rtl/seg_mask_finder.sv
module seg_mask_finder #(
  parameter int NCELL = 4,
  parameter int NWIRE = 12,
  parameter int NMASK = 16,
  parameter int OUTER = 0,
  parameter int LIMW  = 2,
  parameter int CODEW = 5,
  localparam int PATW   = 2 * NWIRE,
  localparam int NSLOPE = 3,
  localparam int NPIX   = (OUTER != 0) ? NSLOPE * (NWIRE / 2) : NWIRE,
  localparam int ADDRW  = (NMASK > 1) ? $clog2(NMASK) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NCELL*PATW-1:0] in_hits,
  input  logic [LIMW-1:0]       miss_lim,
  input  logic                  cfg_we,
  input  logic [ADDRW-1:0]      cfg_addr,
  input  logic [PATW-1:0]       cfg_pat,
  input  logic [CODEW-1:0]      cfg_code,
  output logic                  out_valid,
  output logic [NCELL*NPIX-1:0] out_pix
);
  logic [NMASK*PATW-1:0]  pat_all;
  logic [NMASK*CODEW-1:0] code_all;
  logic [NMASK*CODEW-1:0] code_a;
  logic                   valid_a;

  sf_mask_table #(.NMASK(NMASK), .PATW(PATW), .CODEW(CODEW), .ADDRW(ADDRW)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wpat(cfg_pat),
    .wcode(cfg_code), .pat_all(pat_all), .code_all(code_all)
  );

  // Codes travel with the event so that a later table write cannot alter it.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_a   <= 1'b0;
      code_a    <= '1;
      out_valid <= 1'b0;
    end else begin
      valid_a   <= in_valid;
      code_a    <= code_all;
      out_valid <= valid_a;
    end
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [NMASK-1:0] match_q;

    sf_cell_match #(.NMASK(NMASK), .PATW(PATW), .LIMW(LIMW)) u_match (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .hits(in_hits[c*PATW +: PATW]), .lim(miss_lim),
      .pat_all(pat_all), .match_q(match_q)
    );

    sf_pixel_or #(.NMASK(NMASK), .CODEW(CODEW), .NPIX(NPIX)) u_or (
      .clk(clk), .rst(rst), .valid(valid_a), .match(match_q),
      .codes(code_a), .pix_q(out_pix[c*NPIX +: NPIX])
    );
  end
endmodule

// File: rtl/sf_finder_chk.sv
module sf_finder_chk #(
  parameter int NCELL = 4,
  parameter int NWIRE = 12,
  parameter int OUTER = 0,
  localparam int PATW = 2 * NWIRE,
  localparam int NPIX = (OUTER != 0) ? 3 * (NWIRE / 2) : NWIRE
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [NCELL*PATW-1:0] in_hits,
  input logic                  out_valid,
  input logic [NCELL*NPIX-1:0] out_pix
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  logic same_in, same_out;
  always_comb begin
    same_in  = 1'b1;
    same_out = 1'b1;
    for (int c = 1; c < NCELL; c++) begin
      if (in_hits[c*PATW +: PATW] != in_hits[0 +: PATW]) same_in = 1'b0;
      if (out_pix[c*NPIX +: NPIX] != out_pix[0 +: NPIX]) same_out = 1'b0;
    end
  end

  // R1: the clock after a reset cycle shows cleared outputs
  always @(posedge clk)
    if (rst_seen) a_r1_reset_clear: assert (!out_valid && out_pix == '0);

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  a_r9_idle_latency: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  a_r9_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_pix == '0);

  a_r8_same_cells: assert property (@(posedge clk) disable iff (rst)
    (in_valid && same_in) |=> ##1 same_out);
endmodule

bind seg_mask_finder sf_finder_chk #(.NCELL(NCELL), .NWIRE(NWIRE), .OUTER(OUTER)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_hits(in_hits),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/sim_seg_mask_finder.sv
`timescale 1ns/1ps
module sim_seg_mask_finder;
  localparam int NC = 4, NW = 12, NM = 16, PW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, in_valid = 1'b0, cfg_we = 1'b0;
  logic [NC*PW-1:0] in_hits = '0;
  logic [1:0]    miss_lim = '0;
  logic [3:0]    cfg_addr = '0;
  logic [PW-1:0] cfg_pat = '0;
  logic [4:0]    cfg_code = '0;
  logic          v0, v1;
  logic [NC*12-1:0] pix0;
  logic [NC*18-1:0] pix1;

  seg_mask_finder #(.NCELL(NC), .NWIRE(NW), .NMASK(NM), .OUTER(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hits(in_hits), .miss_lim(miss_lim),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_pat(cfg_pat), .cfg_code(cfg_code),
    .out_valid(v0), .out_pix(pix0));
  seg_mask_finder #(.NCELL(NC), .NWIRE(NW), .NMASK(NM), .OUTER(1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hits(in_hits), .miss_lim(miss_lim),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_pat(cfg_pat), .cfg_code(cfg_code),
    .out_valid(v1), .out_pix(pix1));

  int total = 0, bad = 0;
  logic [PW-1:0] tp [NM];
  logic [4:0]    tc [NM];
  logic [71:0] q0[$], q1[$];
  string       t0[$], t1[$];

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] model(input logic [NC*PW-1:0] h, input logic [1:0] lim, input int npix);
    logic [71:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < NM; m++)
        if ($countones(tp[m] & ~h[c*PW +: PW]) <= int'(lim) && int'(tc[m]) < npix)
          r[c*npix + int'(tc[m])] = 1'b1;
    return r;
  endfunction

  // Driver: presents one event and records the expected pixels.
  task automatic send(input logic [NC*PW-1:0] h, input logic [1:0] lim, input string tag);
    in_valid = 1'b1; in_hits = h; miss_lim = lim;
    q0.push_back(model(h, lim, 12)); t0.push_back({tag, "/R5"});
    q1.push_back(model(h, lim, 18)); t1.push_back({tag, "/R6"});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_hits = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int a, input logic [PW-1:0] p, input logic [4:0] c);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_pat = p; cfg_code = c;
    tp[a] = p; tc[a] = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever a result is presented.
  always @(negedge clk) begin
    if (!rst) begin
      if (v0) begin
        if (q0.size() == 0) check(1'b0, "R9 unexpected result u0", 72'(pix0), '0);
        else begin
          logic [71:0] e; string s;
          e = q0.pop_front(); s = t0.pop_front();
          check(72'(pix0) == e, s, 72'(pix0), e);
        end
      end else if (pix0 != '0) check(1'b0, "R9 pixels without valid u0", 72'(pix0), '0);
      if (v1) begin
        if (q1.size() == 0) check(1'b0, "R9 unexpected result u1", pix1, '0);
        else begin
          logic [71:0] e; string s;
          e = q1.pop_front(); s = t1.pop_front();
          check(pix1 == e, s, pix1, e);
        end
      end else if (pix1 != '0) check(1'b0, "R9 pixels without valid u1", pix1, '0);
    end
  end

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  function automatic logic [PW-1:0] drop_bits(input logic [PW-1:0] p, input int k);
    logic [PW-1:0] r = p;
    int n = 0;
    for (int b = 0; b < PW; b++)
      if (r[b] && n < k) begin r[b] = 1'b0; n++; end
    return r;
  endfunction

  initial begin
    for (int i = 0; i < NM; i++) begin tp[i] = '0; tc[i] = 5'h1f; end
    repeat (3) @(negedge clk);
    check(!v0 && pix0 == '0, "R1 reset u0", 72'(pix0), '0);
    check(!v1 && pix1 == '0, "R1 reset u1", pix1, '0);
    rst = 1'b0;
    @(negedge clk);
    send('1, 2'd3, "R1 empty table");
    idle(3);

    load(0, 24'h000555, 5'd3);
    load(1, 24'hAAA000, 5'd7);
    load(2, 24'h000A95, 5'd3);
    load(3, 24'h555000, 5'd15);
    load(4, 24'h000FFF, 5'd20);
    load(5, 24'hFFFFFF, 5'd0);
    load(6, 24'h00000F, 5'd17);
    load(7, 24'h0F0F00, 5'd11);
    @(negedge clk);

    // R9: latency and valid timing
    send({72'h0, 24'h000555}, 2'd0, "R9 latency");
    check(!v0 && !v1, "R9 not early", {70'h0, v1, v0}, '0);
    idle(3);

    // R4: tolerance sweep at the boundary
    for (int k = 0; k <= 4; k++)
      for (int l = 0; l < 4; l++) begin
        send({72'h0, drop_bits(24'h000555, k)}, 2'(l), "R4 boundary");
        idle(1);
      end

    send({72'h0, 24'h000FFF}, 2'd0, "R3 extra hits");
    send({72'h0, 24'hFFF555}, 2'd0, "R3 extra hits");
    idle(2);
    send('1, 2'd0, "R7 all masks");
    send({NC{24'h000555 | 24'h555000}}, 2'd1, "R7 shared code");
    idle(2);
    send({24'h555000, 24'hAAA000, 24'h000A95, 24'h000555}, 2'd0, "R8 distinct cells");
    send({NC{24'h0F0F05}}, 2'd2, "R8 identical cells");
    idle(3);

    load(0, 24'h000555, 5'd9);
    @(negedge clk);
    send({72'h0, 24'h000555}, 2'd0, "R2 rewrite");
    idle(3);

    // R10: back-to-back burst
    for (int i = 0; i < 12; i++)
      send({NC{24'($urandom)}}, 2'($urandom), "R10 burst");
    idle(3);

    for (int i = 0; i < 200; i++) begin
      logic [NC*PW-1:0] h;
      for (int c = 0; c < NC; c++)
        h[c*PW +: PW] = drop_bits(tp[$urandom % 8], int'($urandom % 5))
                        | (24'($urandom) & 24'($urandom) & 24'($urandom));
      send(h, 2'($urandom), "R4 random");
      if ($urandom % 3 == 0) idle(1);
    end
    idle(4);
    check(q0.size() == 0 && q1.size() == 0, "R9 all results delivered",
          72'(q0.size()), 72'(0));
    finish_up();
  end
endmodule